// File: doc/BRIEF.md
# Flash Censorship Bit Controller

This block owns the two non-volatile censorship bits of a flash memory controller, together with the control fields that sequence operations on them. Software can move a censorship bit from 0 to 1 with a program operation that leaves the memory array untouched. The only way back to 0 is a full erase of the main array plus the shadow region. That erase is armed only by an interlock write, made while every block is selected and none is protected.

A single write port reaches five targets: control, masks, configuration, array and censor data. The high-voltage pulse is modelled as a counter that keeps the busy flag high for `HV_CYCLES` clocks. A pass flag reports whether the last pulse ran a correctly armed operation. A small behavioural array model makes the effect of an erase visible through a read port.

The censorship bits and the array model are reset only by the power-on reset `por_ni`. The register-level reset `rst_ni` clears the control state and leaves them intact.

Top module: `censor_ctrl`

## Requirements
- R1: After `rst_ni`, the following reset values hold: `ctrl_o` = 0, `hv_busy_o` = 0 and `pass_o` = 0. The block-select masks are 0 and all protect bits are 1. After `por_ni`, `censor_o` equals `CENSOR_INIT` and every array word reads all ones.
- R2: A program operation runs when enable-high-voltage rises while the mode is program setup and at least one censor bit has been requested. The mode is encoded in the control write fields: bit0 censor-select = 1, bit1 program/erase = 0 (program), bit2 setup = 1, bit3 enable-high-voltage. Censor requests are written to target 4 with data bits [1:0] = 1 for each requested bit. Such a request is accepted only in program setup. During the operation `hv_busy_o` is 1 for exactly `HV_CYCLES` cycles. Afterwards the requested bits are 1, `pass_o` = 1 and the array is unchanged.
- R3: A program operation never turns a censor bit from 1 to 0.
- R4: An erase operation runs when enable-high-voltage rises while the mode is erase setup (bits [2:0] = 3'b111) and an interlock is armed. When it ends, `censor_o` = 0, every array word reads all ones and `pass_o` = 1.
- R5: An interlock write arms the erase only under these mask conditions. The mask write (target 1) must carry block-select [7:0] = 0xFF and protect [15:8] = 0x00. Shadow block-select sits at [17:16] and shadow protect at [19:18]. For each shadow block enabled in configuration bits [2:1], its shadow block-select must be 1 and its shadow protect must be 0. Any later mask write disarms the interlock.
- R6: With configuration bit0 (interlock-select) = 0, only an array write (target 3) to an address below `ARRAY_WORDS` is an interlock write. A configuration write or a write to an out-of-range address is not.
- R7: With interlock-select = 1, a configuration write (target 2) is also an interlock write.
- R8: A rise of enable-high-voltage without a valid setup does not start an operation. The same holds for a program request with no censor bit requested, and for an erase that is not armed. In these cases busy stays 0, `pass_o` reads 0 and the censor bits are unchanged.
- R9: While `hv_busy_o` = 1, all writes to every target are ignored.
- R10: `rst_ni` alone leaves `censor_o` and the array contents unchanged.
- R11: An array write with setup = 0 to an address below `ARRAY_WORDS` stores data [DW-1:0] there. Out-of-range reads return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous register reset |
| por_ni | input | 1 | Active-low asynchronous power-on reset for non-volatile state |
| wr_i | input | 1 | Write strobe |
| wr_tgt_i | input | 3 | Target: 0 control, 1 masks, 2 config, 3 array, 4 censor data |
| wr_addr_i | input | AW | Array word address for target 3 |
| wr_data_i | input | 20 | Write data |
| rd_addr_i | input | AW | Array read address |
| rd_data_o | output | DW | Array read data |
| ctrl_o | output | 4 | Control fields {ehv, setup, pe, csel} |
| censor_o | output | 2 | Censorship bits |
| hv_busy_o | output | 1 | High-voltage operation in progress |
| pass_o | output | 1 | Last operation completed correctly armed |

## Verification
The bench attacks the erase interlock from every side. It sends a configuration write while interlock-select is 0, an array write to an out-of-range address, a mask missing one block, a stray protect bit, and an enabled shadow block left unselected. A design that arms on any of these erases the censorship bits when it should not. The bench also fires writes into a running pulse; a design that does not block them changes the control fields or corrupts the array mid-operation. Finally, it pulses the register reset alone after the bits are set, which exposes a design that ties the non-volatile bits to the wrong reset.

// File: rtl/censor_pkg.sv
package censor_pkg;
  localparam int NBLK = 8;
  localparam int NSHD = 2;

  typedef enum logic [2:0] {
    TGT_CTRL   = 3'd0,
    TGT_MASK   = 3'd1,
    TGT_CFG    = 3'd2,
    TGT_ARRAY  = 3'd3,
    TGT_CENSOR = 3'd4
  } tgt_e;

  typedef struct packed {
    logic ehv;
    logic setup;
    logic pe;
    logic csel;
  } ctrl_t;

  typedef struct packed {
    logic [NSHD-1:0] sprot;
    logic [NSHD-1:0] sblk;
    logic [NBLK-1:0] prot;
    logic [NBLK-1:0] blk;
  } mask_t;

  typedef struct packed {
    logic [NSHD-1:0] shd_en;
    logic            iws;
  } cfg_t;

  localparam int WR_W = $bits(mask_t);
  localparam mask_t MASK_RST = '{sprot: '1, sblk: '0, prot: '1, blk: '0};

  function automatic logic is_erase_mode(ctrl_t c);
    return c.csel && c.pe && c.setup;
  endfunction

  function automatic logic is_prog_mode(ctrl_t c);
    return c.csel && !c.pe && c.setup;
  endfunction
endpackage

// File: rtl/censor_intlk.sv
module censor_intlk
  import censor_pkg::*;
(
  input  mask_t           mask_i,
  input  logic [NSHD-1:0] shd_en_i,
  output logic            mask_ok_o
);
  logic [NSHD-1:0] shd_ok;

  for (genvar s = 0; s < NSHD; s++) begin : g_shd
    assign shd_ok[s] = !shd_en_i[s] || (mask_i.sblk[s] && !mask_i.sprot[s]);
  end

  assign mask_ok_o = (&mask_i.blk) && !(|mask_i.prot) && (&shd_ok);
endmodule

// File: rtl/censor_hv_timer.sv
module censor_hv_timer #(
  parameter int HV_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(HV_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(HV_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= LAST;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  a_r2_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o);
  a_r2_start_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
endmodule

// File: rtl/censor_nvm.sv
module censor_nvm #(
  parameter int         WORDS       = 12,
  parameter int         AW          = 4,
  parameter int         DW          = 16,
  parameter logic [1:0] CENSOR_INIT = 2'b00
) (
  input  logic          clk_i,
  input  logic          por_ni,
  input  logic          prog_done_i,
  input  logic          erase_done_i,
  input  logic [1:0]    pend_i,
  input  logic          arr_we_i,
  input  logic [AW-1:0] arr_addr_i,
  input  logic [DW-1:0] arr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic [1:0]    censor_o
);
  logic [1:0]    censor_q;
  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)            censor_q <= CENSOR_INIT;
    else if (erase_done_i)  censor_q <= '0;
    else if (prog_done_i)   censor_q <= censor_q | pend_i;
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge por_ni) begin
      if (!por_ni)                                            mem_q[w] <= '1;
      else if (erase_done_i)                                  mem_q[w] <= '1;
      else if (arr_we_i && (arr_addr_i == AW'(w)))            mem_q[w] <= arr_data_i;
    end
  end

  assign rd_data_o = (32'(rd_addr_i) < WORDS) ? mem_q[rd_addr_i] : '0;
  assign censor_o  = censor_q;

  a_r3_no_clear_wo_erase: assert property (@(posedge clk_i) disable iff (!por_ni)
    !erase_done_i |=> ((censor_q & $past(censor_q)) == $past(censor_q)));
  a_r4_erase_clears: assert property (@(posedge clk_i) disable iff (!por_ni)
    erase_done_i |=> (censor_q == 2'b00));
endmodule

// File: rtl/censor_ctrl.sv
module censor_ctrl
  import censor_pkg::*;
#(
  parameter int         HV_CYCLES   = 8,
  parameter int         ARRAY_WORDS = 12,
  parameter int         AW          = 4,
  parameter int         DW          = 16,
  parameter logic [1:0] CENSOR_INIT = 2'b00
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            por_ni,
  input  logic            wr_i,
  input  logic [2:0]      wr_tgt_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [WR_W-1:0] wr_data_i,
  input  logic [AW-1:0]   rd_addr_i,
  output logic [DW-1:0]   rd_data_o,
  output logic [3:0]      ctrl_o,
  output logic [1:0]      censor_o,
  output logic            hv_busy_o,
  output logic            pass_o
);
  ctrl_t      ctrl_q, wctrl;
  mask_t      mask_q;
  cfg_t       cfg_q;
  logic       armed_q, pass_q, erase_op_q;
  logic [1:0] pend_q;
  logic       busy, done, mask_ok, addr_ok;
  logic       wr_ctrl, wr_mask, wr_cfg, wr_arr, wr_cen;
  logic       ehv_rise, start_prog, start_erase, intlk_hit;

  assign wctrl   = ctrl_t'(wr_data_i[3:0]);
  assign addr_ok = 32'(wr_addr_i) < ARRAY_WORDS;

  // writes are dropped while the pulse runs
  assign wr_ctrl = wr_i && !busy && (tgt_e'(wr_tgt_i) == TGT_CTRL);
  assign wr_mask = wr_i && !busy && (tgt_e'(wr_tgt_i) == TGT_MASK);
  assign wr_cfg  = wr_i && !busy && (tgt_e'(wr_tgt_i) == TGT_CFG);
  assign wr_arr  = wr_i && !busy && (tgt_e'(wr_tgt_i) == TGT_ARRAY);
  assign wr_cen  = wr_i && !busy && (tgt_e'(wr_tgt_i) == TGT_CENSOR);

  assign ehv_rise    = wr_ctrl && wctrl.ehv && !ctrl_q.ehv;
  assign start_prog  = ehv_rise && is_prog_mode(wctrl) && (|pend_q);
  assign start_erase = ehv_rise && is_erase_mode(wctrl) && armed_q;
  assign intlk_hit   = is_erase_mode(ctrl_q) && mask_ok &&
                       ((wr_arr && addr_ok) || (wr_cfg && cfg_q.iws));

  censor_intlk u_intlk (
    .mask_i    (mask_q),
    .shd_en_i  (cfg_q.shd_en),
    .mask_ok_o (mask_ok)
  );

  censor_hv_timer #(.HV_CYCLES(HV_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_prog || start_erase),
    .busy_o  (busy),
    .done_o  (done)
  );

  censor_nvm #(
    .WORDS(ARRAY_WORDS), .AW(AW), .DW(DW), .CENSOR_INIT(CENSOR_INIT)
  ) u_nvm (
    .clk_i        (clk_i),
    .por_ni       (por_ni),
    .prog_done_i  (done && !erase_op_q),
    .erase_done_i (done && erase_op_q),
    .pend_i       (pend_q),
    .arr_we_i     (wr_arr && addr_ok && !ctrl_q.setup),
    .arr_addr_i   (wr_addr_i),
    .arr_data_i   (wr_data_i[DW-1:0]),
    .rd_addr_i    (rd_addr_i),
    .rd_data_o    (rd_data_o),
    .censor_o     (censor_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      mask_q     <= MASK_RST;
      cfg_q      <= '0;
      armed_q    <= 1'b0;
      pend_q     <= '0;
      pass_q     <= 1'b0;
      erase_op_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= wctrl;
      if (wr_mask) mask_q <= mask_t'(wr_data_i);
      if (wr_cfg)  cfg_q  <= cfg_t'(wr_data_i[2:0]);

      if (done)                                         armed_q <= 1'b0;
      else if (wr_mask)                                 armed_q <= 1'b0;
      else if (wr_ctrl && !is_erase_mode(wctrl))        armed_q <= 1'b0;
      else if (intlk_hit)                               armed_q <= 1'b1;

      if (done)                                         pend_q <= '0;
      else if (wr_cen && is_prog_mode(ctrl_q))          pend_q <= pend_q | wr_data_i[1:0];

      if (done)          pass_q <= 1'b1;
      else if (ehv_rise) pass_q <= 1'b0;

      if (start_prog || start_erase) erase_op_q <= start_erase;
    end
  end

  assign ctrl_o    = ctrl_q;
  assign hv_busy_o = busy;
  assign pass_o    = pass_q;

  a_r8_busy_needs_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> (ctrl_q.ehv && ctrl_q.setup && ctrl_q.csel));
  a_r9_regs_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> ($stable(mask_q) && $stable(cfg_q)));
  a_r2_pass_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pass_q) |-> $past(done));
endmodule

// File: tb/censor_ctrl_tb_top.sv
`timescale 1ns/1ps
module censor_ctrl_tb_top;
  localparam int HV = 5;
  localparam int WORDS = 12;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam logic [1:0] CINIT = 2'b00;

  logic clk_i = 1'b0, rst_ni = 1'b0, por_ni = 1'b0;
  logic wr_i = 1'b0;
  logic [2:0] wr_tgt_i = '0;
  logic [AW-1:0] wr_addr_i = '0, rd_addr_i = '0;
  logic [19:0] wr_data_i = '0;
  logic [DW-1:0] rd_data_o;
  logic [3:0] ctrl_o;
  logic [1:0] censor_o;
  logic hv_busy_o, pass_o;

  int checks = 0, fails = 0;

  always #2.5 clk_i = ~clk_i;

  censor_ctrl #(.HV_CYCLES(HV), .ARRAY_WORDS(WORDS), .AW(AW), .DW(DW),
                .CENSOR_INIT(CINIT)) dut_i (.*);

  // behavioural reference
  int m_ctrl, m_mask, m_cfg, m_pend, m_left, m_cen;
  bit m_armed, m_busy, m_pass, m_erase;
  int m_mem[WORDS];

  function automatic bit m_mask_ok();
    bit ok = ((m_mask & 'hFF) == 'hFF) && (((m_mask >> 8) & 'hFF) == 0);
    for (int s = 0; s < 2; s++)
      if ((m_cfg >> (1 + s)) & 1)
        ok = ok && ((m_mask >> (16 + s)) & 1) && !((m_mask >> (18 + s)) & 1);
    return ok;
  endfunction

  task automatic m_regreset();
    m_ctrl = 0; m_mask = 'hCFF00; m_cfg = 0; m_pend = 0; m_left = 0;
    m_armed = 0; m_busy = 0; m_pass = 0; m_erase = 0;
  endtask

  task automatic m_step();
    int d = int'(wr_data_i);
    if (!por_ni) begin
      m_regreset(); m_cen = int'(CINIT);
      for (int w = 0; w < WORDS; w++) m_mem[w] = 'hFFFF;
    end else if (!rst_ni) begin
      m_regreset();
    end else if (m_busy) begin
      m_left--;
      if (m_left == 0) begin
        m_busy = 0; m_pass = 1; m_armed = 0;
        if (m_erase) begin
          m_cen = 0;
          for (int w = 0; w < WORDS; w++) m_mem[w] = 'hFFFF;
        end else m_cen = m_cen | m_pend;
        m_pend = 0;
      end
    end else if (wr_i) begin
      case (int'(wr_tgt_i))
        0: begin
          int nc = d & 15;
          bit rise = ((nc & 8) != 0) && ((m_ctrl & 8) == 0);
          if (rise) m_pass = 0;
          if ((nc & 7) != 7) m_armed = 0;
          if (rise && (nc & 7) == 5 && m_pend != 0) begin
            m_busy = 1; m_left = HV; m_erase = 0;
          end else if (rise && (nc & 7) == 7 && m_armed) begin
            m_busy = 1; m_left = HV; m_erase = 1;
          end
          m_ctrl = nc;
        end
        1: begin m_mask = d; m_armed = 0; end
        2: begin
          if ((m_ctrl & 7) == 7 && (m_cfg & 1) && m_mask_ok()) m_armed = 1;
          m_cfg = d & 7;
        end
        3: if (int'(wr_addr_i) < WORDS) begin
          if ((m_ctrl & 7) == 7 && m_mask_ok()) m_armed = 1;
          if ((m_ctrl & 4) == 0) m_mem[int'(wr_addr_i)] = d & 'hFFFF;
        end
        4: if ((m_ctrl & 7) == 5) m_pend = m_pend | (d & 3);
        default: ;
      endcase
    end
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    m_step();
    #2;
    chk("R2 R4 censor_o per-cycle", int'(censor_o), m_cen);
    chk("R2 hv_busy_o per-cycle", int'(hv_busy_o), int'(m_busy));
    chk("R8 pass_o per-cycle", int'(pass_o), int'(m_pass));
    chk("R9 ctrl_o per-cycle", int'(ctrl_o), m_ctrl);
    chk("R11 rd_data_o per-cycle", int'(rd_data_o),
        (int'(rd_addr_i) < WORDS) ? m_mem[int'(rd_addr_i)] : 0);
  end

  task automatic wr_op(int tgt, int addr, int data);
    @(negedge clk_i);
    wr_i = 1'b1; wr_tgt_i = 3'(tgt); wr_addr_i = AW'(addr); wr_data_i = 20'(data);
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (hv_busy_o) begin n++; @(negedge clk_i); end
  endtask

  task automatic rd(int a, output int v);
    rd_addr_i = AW'(a); #0.5; v = int'(rd_data_o);
  endtask

  localparam int MASK_ALL = 'h000FF;

  initial begin
    int n, v;
    rd_addr_i = AW'(3);
    repeat (3) @(negedge clk_i);
    por_ni = 1'b1; rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 censor after por", int'(censor_o), int'(CINIT));
    chk("R1 busy after reset", int'(hv_busy_o), 0);
    chk("R1 pass after reset", int'(pass_o), 0);
    chk("R1 ctrl after reset", int'(ctrl_o), 0);
    rd(0, v); chk("R1 array erased after por", v, 'hFFFF);
    rd_addr_i = AW'(3);

    wr_op(3, 3, 'hA5A5);
    rd(3, v); chk("R11 array store", v, 'hA5A5);
    rd(14, v); chk("R11 out-of-range read", v, 0);
    rd_addr_i = AW'(3);

    // R8: enable without setup
    wr_op(0, 0, 8);
    chk("R8 no busy without setup", int'(hv_busy_o), 0);
    chk("R8 no pass without setup", int'(pass_o), 0);
    wr_op(0, 0, 0);
    // R8: program setup but no bit requested
    wr_op(0, 0, 5); wr_op(0, 0, 13);
    chk("R8 no op without request", int'(hv_busy_o), 0);
    wr_op(0, 0, 5);

    // R2: set bit 1
    wr_op(4, 0, 2);
    wr_op(0, 0, 13);
    wait_idle(n);
    chk("R2 busy length", n, HV);
    chk("R2 censor set", int'(censor_o), 2);
    chk("R2 pass", int'(pass_o), 1);
    rd(3, v); chk("R2 array untouched by set", v, 'hA5A5);
    wr_op(0, 0, 5);

    // R3 + R9: set bit 0, writes during pulse
    wr_op(4, 0, 1);
    wr_op(0, 0, 13);
    wr_op(0, 0, 0);
    wr_op(3, 3, 'h1234);
    wait_idle(n);
    chk("R9 ctrl write ignored when busy", int'(ctrl_o), 13);
    rd(3, v); chk("R9 array write ignored when busy", v, 'hA5A5);
    chk("R3 earlier bit kept", int'(censor_o), 3);
    wr_op(0, 0, 5); wr_op(0, 0, 0);

    // R6: interlock-select 0
    wr_op(0, 0, 7);
    wr_op(1, 0, MASK_ALL);
    wr_op(2, 0, 0);
    wr_op(0, 0, 15);
    chk("R6 cfg write not interlock", int'(hv_busy_o), 0);
    chk("R6 censor kept", int'(censor_o), 3);
    wr_op(0, 0, 7);
    wr_op(3, 13, 0);
    wr_op(0, 0, 15);
    chk("R6 bad address not interlock", int'(hv_busy_o), 0);
    wr_op(0, 0, 7);

    // R5: shadow 0 enabled
    wr_op(2, 0, 2);
    wr_op(1, 0, MASK_ALL);
    wr_op(3, 0, 0); wr_op(0, 0, 15);
    chk("R5 shadow unselected", int'(hv_busy_o), 0);
    wr_op(0, 0, 7);
    wr_op(1, 0, 'h1007F);
    wr_op(3, 0, 0); wr_op(0, 0, 15);
    chk("R5 missing block", int'(hv_busy_o), 0);
    wr_op(0, 0, 7);
    wr_op(1, 0, 'h104FF);
    wr_op(3, 0, 0); wr_op(0, 0, 15);
    chk("R5 protected block", int'(hv_busy_o), 0);
    chk("R5 censor kept", int'(censor_o), 3);
    wr_op(0, 0, 7);
    wr_op(1, 0, 'h100FF);
    wr_op(3, 2, 0); wr_op(0, 0, 15);
    chk("R4 erase starts", int'(hv_busy_o), 1);
    wait_idle(n);
    chk("R4 censor cleared", int'(censor_o), 0);
    chk("R4 pass", int'(pass_o), 1);
    rd(3, v); chk("R4 array erased", v, 'hFFFF);
    wr_op(0, 0, 7); wr_op(0, 0, 0);

    // R7: interlock-select 1
    wr_op(0, 0, 5); wr_op(4, 0, 2); wr_op(0, 0, 13);
    wait_idle(n);
    wr_op(0, 0, 5);
    wr_op(0, 0, 7);
    wr_op(1, 0, MASK_ALL);
    wr_op(2, 0, 1);
    wr_op(2, 0, 1);
    wr_op(0, 0, 15);
    chk("R7 cfg write arms", int'(hv_busy_o), 1);
    wait_idle(n);
    chk("R7 censor cleared", int'(censor_o), 0);
    wr_op(0, 0, 7); wr_op(0, 0, 0);

    // R10
    wr_op(3, 5, 'h5A5A);
    wr_op(0, 0, 5); wr_op(4, 0, 1); wr_op(0, 0, 13);
    wait_idle(n);
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R10 censor kept over rst", int'(censor_o), 1);
    chk("R10 ctrl cleared", int'(ctrl_o), 0);
    rd(5, v); chk("R10 array kept over rst", v, 'h5A5A);
    @(negedge clk_i); por_ni = 1'b0;
    @(negedge clk_i); por_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 censor after por", int'(censor_o), int'(CINIT));

    repeat (2) @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    fails++;
    $display("FAIL watchdog R2 actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule